// File: doc/BRIEF.md
# Four-Channel Compare Timer

This block is a memory-mapped timer with one free-running 32-bit up-counter and four compare channels. The counter advances by one on every cycle in which the timer tick input is high, and it wraps from all-ones to zero. Software can overwrite the counter at any time, and counting then continues from the written value. Each channel holds a compare value. When the counter meets that value on a tick, the channel's status flag is latched. The flag drives that channel's interrupt line only while the channel's enable bit is set.

Software acknowledges an event by writing one to its status bit. Writes of zero leave the other flags as they are. A typical one-shot use reads the counter, writes the counter value plus a delta into a compare register, enables that channel, and on the interrupt clears the flag and disables the channel.

A separate enable register can arm channel 3 as a watchdog. Once software arms it, the arming cannot be undone until system reset, and each channel 3 match then raises a single-cycle reset request.

Top module: `match_timer`

## Requirements
- R1: After reset the counter, all compare values, status, interrupt enables and the watchdog arm bit read 0, and `irqOut` and `wdtResetReq` are low.
- R2: The counter (word offset 0x10) increments by one on each clock edge where `tickEn` is high and wraps from 0xFFFFFFFF to 0. A match does not reset it.
- R3: A bus write to the counter loads the written value. If `tickEn` is high in the same cycle, the written value wins over the increment.
- R4: Status bit n (bits 3:0 at offset 0x14) is set at a clock edge where `tickEn` is high and the counter equals compare register n (offsets 0x00, 0x04, 0x08, 0x0C). The bit stays set. A match in the same cycle as a clear of that bit leaves it set.
- R5: `irqOut[n]` is high exactly when status bit n and interrupt enable bit n (bits 3:0 at offset 0x1C) are both 1. Status bits still set while their enable bit is 0.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: Compare registers hold any 32-bit value. They read back what was written and can be rewritten at any time.
- R8: Writing 1 to bit 0 at offset 0x18 arms the watchdog. Writing 0 has no effect, and only reset clears the bit.
- R9: While the watchdog is armed, each channel 3 match raises `wdtResetReq` for exactly the one cycle after the matching clock edge. While it is not armed, `wdtResetReq` stays low.
- R10: Read data is combinational while `busSel` is high and `busWr` is low. Unused high bits of status, interrupt enable and watchdog registers read 0. Offsets 0x20 to 0x3C, and any address with its two low bits nonzero, read 0 and ignore writes.
- R11: Writing 0 to the interrupt enable register and 0xF to the status register leaves all interrupt lines low and status reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer tick qualifier; counter advances and compares evaluate when high |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| irqOut | output | 4 | Per-channel interrupt lines |
| wdtResetReq | output | 1 | Single-cycle watchdog reset request |

## Verification
The bench targets four corner cases. It overwrites the counter in a cycle that also ticks; a design that lets the increment win reads back one too high. It clears a status flag in the same cycle that the flag's channel matches; a design where the clear wins drops that event. It writes zero to the watchdog arm bit, and it lets the counter roll over from all-ones; a design with an unsticky arm bit, or with a carry that does not wrap, reads back the wrong value. It also checks that a flag latched while its interrupt was masked, and a channel 3 match while the watchdog is unarmed, stay off the output pins until the enable or arm bit is set.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef enum logic [2:0] {
    RD_NONE, RD_MATCH, RD_CNT, RD_STATUS, RD_WDT, RD_IER
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0] matchWr;
    logic              cntWr;
    logic              statusWr;
    logic              ierWr;
    logic              wdtWr;
    rdSel_e            rdSel;
    logic [CH_W-1:0]   rdCh;
  } ctrlStrb_t;
endpackage

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import match_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrb_t         strb
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] CNT_IDX    = WORD_W'(NUM_CH);
  localparam logic [WORD_W-1:0] STATUS_IDX = WORD_W'(NUM_CH + 1);
  localparam logic [WORD_W-1:0] WDT_IDX    = WORD_W'(NUM_CH + 2);
  localparam logic [WORD_W-1:0] IER_IDX    = WORD_W'(NUM_CH + 3);

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strb = '0;
    if (busSel && aligned) begin
      if (wordIdx < CNT_IDX) begin
        if (busWr) strb.matchWr[wordIdx[CH_W-1:0]] = 1'b1;
        else begin
          strb.rdSel = RD_MATCH;
          strb.rdCh  = wordIdx[CH_W-1:0];
        end
      end else begin
        case (wordIdx)
          CNT_IDX:    if (busWr) strb.cntWr    = 1'b1; else strb.rdSel = RD_CNT;
          STATUS_IDX: if (busWr) strb.statusWr = 1'b1; else strb.rdSel = RD_STATUS;
          WDT_IDX:    if (busWr) strb.wdtWr    = 1'b1; else strb.rdSel = RD_WDT;
          IER_IDX:    if (busWr) strb.ierWr    = 1'b1; else strb.rdSel = RD_IER;
          default:    strb.rdSel = RD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mt_datapath.sv
module mt_datapath
  import match_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irqOut,
  output logic              wdtReq,
  output logic [DATA_W-1:0] cntQ,
  output logic [NUM_CH-1:0] statusQ,
  output logic [NUM_CH-1:0] ierQ,
  output logic              wdtEnQ
);
  logic [DATA_W-1:0] matchQ [NUM_CH];
  logic [NUM_CH-1:0] hit;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   matchQ[ch] <= '0;
      else if (strb.matchWr[ch])   matchQ[ch] <= wdata;
    end
    // compare sees the count held in this cycle, before any load or step
    assign hit[ch] = tickEn && (cntQ == matchQ[ch]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (strb.cntWr)  cntQ <= wdata;
    else if (tickEn)      cntQ <= cntQ + DATA_W'(1);
  end

  // a fresh match outranks an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (strb.statusWr ? (statusQ & ~wdata[NUM_CH-1:0]) : statusQ) | hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ierQ <= '0;
    else if (strb.ierWr)  ierQ <= wdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtEnQ <= 1'b0;
      wdtReq <= 1'b0;
    end else begin
      if (strb.wdtWr && wdata[0]) wdtEnQ <= 1'b1;
      wdtReq <= wdtEnQ && hit[NUM_CH-1];
    end
  end

  assign irqOut = statusQ & ierQ;

  always_comb begin
    case (strb.rdSel)
      RD_MATCH:  rdata = matchQ[strb.rdCh];
      RD_CNT:    rdata = cntQ;
      RD_STATUS: rdata = DATA_W'(statusQ);
      RD_WDT:    rdata = DATA_W'(wdtEnQ);
      RD_IER:    rdata = DATA_W'(ierQ);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irqOut,
  output logic              wdtResetReq
);
  ctrlStrb_t         strb;
  logic [DATA_W-1:0] cntQ;
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] ierQ;
  logic              wdtEnQ;

  mt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  mt_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .strb   (strb),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .irqOut (irqOut),
    .wdtReq (wdtResetReq),
    .cntQ   (cntQ),
    .statusQ(statusQ),
    .ierQ   (ierQ),
    .wdtEnQ (wdtEnQ)
  );
endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import match_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input ctrlStrb_t         strb,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] cntQ,
  input logic [NUM_CH-1:0] statusQ,
  input logic [NUM_CH-1:0] ierQ,
  input logic [NUM_CH-1:0] irqOut,
  input logic              wdtEnQ,
  input logic              wdtReq
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strb.cntWr) |=> cntQ == $past(cntQ) + DATA_W'(1));

  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntWr |=> cntQ == $past(wdata));

  // R4
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strb.statusWr) |=> $stable(statusQ));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~(statusQ & ierQ)) == '0);

  // R8
  wdt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtEnQ |=> wdtEnQ);

  // R9
  wdt_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtReq |-> $past(wdtEnQ));
endmodule

bind match_timer mt_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .tickEn (tickEn),
  .strb   (strb),
  .wdata  (busWdata),
  .cntQ   (cntQ),
  .statusQ(statusQ),
  .ierQ   (ierQ),
  .irqOut (irqOut),
  .wdtEnQ (wdtEnQ),
  .wdtReq (wdtResetReq)
);

// File: tb/tb_match_timer.sv
module tb_match_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_M0 = 6'h00, A_M1 = 6'h04, A_M2 = 6'h08, A_M3 = 6'h0C;
  localparam logic [5:0] A_CNT = 6'h10, A_ST = 6'h14, A_WDT = 6'h18, A_IER = 6'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  irqOut;
  logic        wdtResetReq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  match_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .wdtResetReq(wdtResetReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; tickEn = tk;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; tickEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(A_CNT, d);  check("R1 counter", d, 0);
    busRead(A_M2, d);   check("R1 match2", d, 0);
    busRead(A_ST, d);   check("R1 status", d, 0);
    busRead(A_IER, d);  check("R1 ier", d, 0);
    busRead(A_WDT, d);  check("R1 wdt", d, 0);
    check("R1 irq", 32'(irqOut), 0);
    check("R1 wdtReq", 32'(wdtResetReq), 0);
  endtask

  task automatic testMatchRegs();
    logic [31:0] d;
    busWrite(A_M0, 32'd1000);
    busWrite(A_M1, 32'd2000);
    busWrite(A_M2, 32'd3000);
    busWrite(A_M3, 32'hDEAD_BEEF);
    busRead(A_M3, d); check("R7 match3 readback", d, 32'hDEAD_BEEF);
    busWrite(A_M3, 32'd4000);
    busRead(A_M3, d); check("R7 match3 reload", d, 32'd4000);
    busRead(A_M1, d); check("R7 match1 readback", d, 32'd2000);
    busWrite(A_ST, 32'hF);
  endtask

  task automatic testCounter();
    logic [31:0] d;
    busWrite(A_CNT, 32'd100);
    ticks(5);
    busRead(A_CNT, d); check("R2 count steps", d, 32'd105);
    busWrite(A_CNT, 32'hFFFF_FFFF);
    ticks(1);
    busRead(A_CNT, d); check("R2 wrap", d, 32'd0);
    busWrite(A_CNT, 32'd500, 1'b1);
    busRead(A_CNT, d); check("R3 write beats tick", d, 32'd500);
  endtask

  task automatic testStatusIrq();
    logic [31:0] d;
    busWrite(A_CNT, 32'd998);
    ticks(2);
    busRead(A_ST, d); check("R4 no early set", d, 0);
    ticks(1);
    busRead(A_ST, d); check("R4 set on match", d, 32'h1);
    busRead(A_CNT, d); check("R2 not reset by match", d, 32'd1001);
    ticks(3);
    busRead(A_ST, d); check("R4 sticky", d, 32'h1);
    check("R5 masked irq", 32'(irqOut), 0);
    busWrite(A_IER, 32'h1);
    check("R5 irq0 raised", 32'(irqOut), 32'h1);
    busWrite(A_CNT, 32'd2000);
    ticks(1);
    busRead(A_ST, d); check("R4 ch1 set", d, 32'h3);
    check("R5 irq1 masked", 32'(irqOut), 32'h1);
    busWrite(A_ST, 32'h0);
    busRead(A_ST, d); check("R6 zero write", d, 32'h3);
    busWrite(A_ST, 32'h2);
    busRead(A_ST, d); check("R6 one bit cleared", d, 32'h1);
    busWrite(A_CNT, 32'd3000);
    ticks(1);
    busWrite(A_CNT, 32'd3000);
    busWrite(A_ST, 32'h4, 1'b1);
    busRead(A_ST, d); check("R4 match beats clear", d, 32'h5);
    busWrite(A_ST, 32'h4);
    busRead(A_ST, d); check("R6 ch2 cleared", d, 32'h1);
  endtask

  task automatic testWatchdog();
    logic [31:0] d;
    busWrite(A_CNT, 32'd4000);
    @(negedge clk); tickEn = 1'b1;
    @(posedge clk); #1 tickEn = 1'b0;
    check("R9 unarmed no request", 32'(wdtResetReq), 0);
    @(posedge clk); #1;
    check("R9 unarmed still low", 32'(wdtResetReq), 0);
    busRead(A_ST, d); check("R4 ch3 set", d & 32'h8, 32'h8);
    busWrite(A_WDT, 32'h1);
    busWrite(A_WDT, 32'h0);
    busRead(A_WDT, d); check("R8 sticky arm", d, 32'h1);
    busWrite(A_CNT, 32'd4000);
    @(negedge clk); tickEn = 1'b1;
    @(posedge clk); #1 tickEn = 1'b0;
    check("R9 request pulse", 32'(wdtResetReq), 1);
    @(posedge clk); #1;
    check("R9 pulse one cycle", 32'(wdtResetReq), 0);
  endtask

  task automatic testMapQuiet();
    logic [31:0] d;
    busWrite(6'h20, 32'hFFFF_FFFF);
    busRead(6'h20, d); check("R10 unmapped read", d, 0);
    busWrite(6'h01, 32'h1234);
    busRead(A_M0, d); check("R10 unaligned ignored", d, 32'd1000);
    busWrite(A_IER, 32'hFFFF_FFFF);
    busRead(A_IER, d); check("R10 reserved ier bits", d, 32'hF);
    check("R5 all enabled", 32'(irqOut), 32'h9);
    busWrite(A_IER, 32'h0);
    busWrite(A_ST, 32'hF);
    busRead(A_ST, d); check("R11 status quiet", d, 0);
    check("R11 irq quiet", 32'(irqOut), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMatchRegs();
    testCounter();
    testStatusIrq();
    testWatchdog();
    testMapQuiet();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout got=%h exp=%h", 32'd0, 32'd1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule